// File: doc/BRIEF.md
# Byte-Sequential Result Output Port

This block hands a pair of 32-bit result words to a host over an 8-bit parallel bus. An accumulator upstream emits a one-cycle capture pulse together with two words: the elapsed time of the integration window and the integral collected over it. The host asks for data by pulling an active-low request line low. The port synchronizes that line and detects its falling edge. It then waits for the next capture pulse, latches both words, and raises a busy/acknowledge status line. After that it places eight bytes on the bus one at a time: the elapsed-time word first, then the integral word, each starting from its most significant byte. A second status line strobes high once per byte to mark the byte as valid.

The busy/acknowledge line also serves as the no-data flag. While the autozero/reset input is held low, any transfer in progress is abandoned and the line is held high. It falls again once collection resumes. An active-low output enable controls the bus driver. The port gives the pad ring a drive-enable and forces its data to zero whenever the bus is disabled. Byte valid time and byte cycle time are parameters counted in clock cycles. The defaults are 20 and 40 cycles, which gives 1 µs and 2 µs at 20 MHz.

Top module: `res_byte_port`

## Requirements
- R1: After reset, `s1_o` and `s0_o` are both 0.
- R2: After a falling edge on `req_n`, `s1_o` stays 0 until the next `cap_valid` pulse. It is 1 in the first cycle after the edge that samples `cap_valid`.
- R3: Each burst carries exactly 8 bytes on `data_o`, sampled while `s0_o` is high. The order is `cap_time[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, then `cap_integ[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`.
- R4: `s0_o` stays high for exactly VALID_CYC cycles per byte (default 20). Successive rising edges of `s0_o` are BYTE_CYC cycles apart (default 40).
- R5: `data_o` does not change while `s0_o` stays high.
- R6: `s0_o` is high only while `s1_o` is high. `s1_o` falls in the cycle right after the last byte's `s0_o` phase ends.
- R7: While `oe_n` is 1, `bus_oe_o` is 0 and `data_o` is 0. While `oe_n` is 0, `bus_oe_o` is 1.
- R8: While `az_n` is low, after the synchronizer delay, `s1_o` is 1 and `s0_o` is 0, and any transfer is abandoned. `s1_o` returns to 0 after `az_n` returns high, and the abandoned transfer does not resume.
- R9: A falling edge on `req_n` while `s1_o` is 1 is ignored. No second burst follows the current one.
- R10: A `cap_valid` pulse with no pending request leaves `s1_o` at 0. Holding `req_n` low does not start another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| az_n | input | 1 | Active-low autozero/reset request (asynchronous) |
| req_n | input | 1 | Active-low data request (asynchronous) |
| cap_valid | input | 1 | One-cycle capture pulse from the accumulator |
| cap_time | input | WORD_W | Elapsed-time word, valid with `cap_valid` |
| cap_integ | input | WORD_W | Integral word, valid with `cap_valid` |
| oe_n | input | 1 | Active-low bus output enable |
| s1_o | output | 1 | Busy / acknowledge / no-data status |
| s0_o | output | 1 | Byte-valid strobe |
| bus_oe_o | output | 1 | Drive enable for the bus pads |
| data_o | output | BUS_W | Byte on the bus |

## Verification
The bench tests four things:
- Whether a request is held off until a capture arrives. A design that acknowledged at once would raise `s1_o` before any words were latched.
- Whether the eight bytes come out in the right order with exact strobe widths and periods. A word swap, byte reversal or off-by-one pacing counter would show up as a wrong byte or a 19/21-cycle strobe.
- Autozero asserted in the middle of a burst. A design that kept streaming, or resumed after release, would show `s0_o` pulses with `s1_o` still set, or a burst with no request.
- Falling edges during a busy burst, and a request held low. A design that queued the stale edge or sensed the level would produce a second, unrequested burst.

// File: rtl/res_port_pkg.sv
package res_port_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2,
      ST_HOLD = 2'd3
   } port_state_e;
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/byte_pacer.sv
module byte_pacer #(
   parameter int BYTE_CYC  = 40,
   parameter int VALID_CYC = 20,
   parameter int NBYTES    = 8,
   localparam int CNT_W    = (BYTE_CYC > 1) ? $clog2(BYTE_CYC) : 1,
   localparam int IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   output logic             busy,
   output logic             strobe,
   output logic             done,
   output logic [IDX_W-1:0] idx
);
   localparam int               LOW_CYC = BYTE_CYC - VALID_CYC;
   localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOW_CYC);
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(BYTE_CYC - 1);
   localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(NBYTES - 1);

   logic [CNT_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt == LAST_C);
   assign strobe = busy && (cnt >= LOW_C);
   assign done   = busy && at_end && (idx == LAST_I);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         idx  <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         cnt  <= '0;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
         idx  <= '0;
      end else if (busy) begin
         if (at_end) begin
            cnt <= '0;
            if (idx == LAST_I) busy <= 1'b0;
            else               idx  <= idx + IDX_W'(1);
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/word_lane_mux.sv
module word_lane_mux #(
   parameter int WORD_W  = 32,
   parameter int BUS_W   = 8,
   localparam int BPW    = WORD_W / BUS_W,
   localparam int NBYTES = 2 * BPW,
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic [WORD_W-1:0] w_first,
   input  logic [WORD_W-1:0] w_second,
   input  logic [IDX_W-1:0]  idx,
   output logic [BUS_W-1:0]  lane_o
);
   logic [BUS_W-1:0] lanes [NBYTES];

   generate
      for (genvar g = 0; g < BPW; g++) begin : g_lane
         assign lanes[g]       = w_first [WORD_W-1-g*BUS_W -: BUS_W];
         assign lanes[BPW + g] = w_second[WORD_W-1-g*BUS_W -: BUS_W];
      end
   endgenerate

   assign lane_o = lanes[idx];
endmodule

// File: rtl/res_byte_port.sv
module res_byte_port
   import res_port_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int BUS_W       = 8,
   parameter int VALID_CYC   = 20,
   parameter int BYTE_CYC    = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              az_n,
   input  logic              req_n,
   input  logic              cap_valid,
   input  logic [WORD_W-1:0] cap_time,
   input  logic [WORD_W-1:0] cap_integ,
   input  logic              oe_n,
   output logic              s1_o,
   output logic              s0_o,
   output logic              bus_oe_o,
   output logic [BUS_W-1:0]  data_o
);
   localparam int BPW    = WORD_W / BUS_W;
   localparam int NBYTES = 2 * BPW;
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   generate
      if (WORD_W % BUS_W != 0) begin : g_bad_width
         $error("WORD_W must be a multiple of BUS_W");
      end
      if (VALID_CYC < 1 || VALID_CYC >= BYTE_CYC) begin : g_bad_timing
         $error("VALID_CYC must lie in 1..BYTE_CYC-1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   port_state_e       state;
   logic [1:0]        raw_in, sync_q;
   logic              req_s, az_s, req_prev, req_fall, az_low;
   logic [WORD_W-1:0] time_q, integ_q;
   logic              p_start, p_busy, p_strobe, p_done;
   logic [IDX_W-1:0]  p_idx;
   logic [BUS_W-1:0]  lane;

   assign raw_in = {az_n, req_n};

   sig_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
   );

   assign {az_s, req_s} = sync_q;
   assign az_low   = !az_s;
   assign req_fall = req_prev && !req_s;
   assign p_start  = (state == ST_WAIT) && cap_valid && !az_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev <= 1'b1;
      else        req_prev <= req_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         time_q  <= '0;
         integ_q <= '0;
      end else if (az_low) begin
         state <= ST_HOLD;
      end else begin
         unique case (state)
            ST_IDLE: if (req_fall) state <= ST_WAIT;
            ST_WAIT: if (cap_valid) begin
               time_q  <= cap_time;
               integ_q <= cap_integ;
               state   <= ST_SEND;
            end
            ST_SEND: if (p_done) state <= ST_IDLE;
            ST_HOLD: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   byte_pacer #(.BYTE_CYC(BYTE_CYC), .VALID_CYC(VALID_CYC), .NBYTES(NBYTES)) u_pacer (
      .clk(clk), .rst_n(rst_n), .start(p_start), .abort(az_low),
      .busy(p_busy), .strobe(p_strobe), .done(p_done), .idx(p_idx)
   );

   word_lane_mux #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_mux (
      .w_first(time_q), .w_second(integ_q), .idx(p_idx), .lane_o(lane)
   );

   assign s1_o     = (state == ST_SEND) || (state == ST_HOLD);
   assign s0_o     = (state == ST_SEND) && p_busy && p_strobe;
   assign bus_oe_o = !oe_n;
   assign data_o   = oe_n ? '0 : lane;
endmodule

// File: rtl/res_byte_port_chk.sv
module res_byte_port_chk #(
   parameter int BUS_W       = 8,
   parameter int VALID_CYC   = 20,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             az_n,
   input logic             cap_valid,
   input logic             oe_n,
   input logic             s1_o,
   input logic             s0_o,
   input logic [BUS_W-1:0] data_o
);
   localparam logic [15:0] AZ_SETTLE = 16'(SYNC_STAGES + 2);
   localparam logic [15:0] AZ_NEAR   = 16'(SYNC_STAGES + 2);

   logic [15:0] hi_run, az_run, since_az;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run   <= '0;
         az_run   <= '0;
         since_az <= 16'hFFFF;
      end else begin
         hi_run   <= s0_o ? hi_run + 16'd1 : 16'd0;
         az_run   <= (!az_n) ? ((az_run == 16'hFFFF) ? az_run : az_run + 16'd1) : 16'd0;
         since_az <= (!az_n) ? 16'd0 : ((since_az == 16'hFFFF) ? since_az : since_az + 16'd1);
      end
   end

   // R2
   ack_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s1_o) |-> ($past(cap_valid) || since_az <= AZ_NEAR));

   // R4
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s0_o |-> (hi_run < 16'(VALID_CYC)));

   // R5
   stable_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_o && $past(s0_o) && !oe_n && $past(!oe_n)) |-> $stable(data_o));

   // R6
   strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s0_o |-> s1_o);

   // R8
   autozero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (az_run >= AZ_SETTLE) |-> (s1_o && !s0_o));
endmodule

bind res_byte_port res_byte_port_chk #(
   .BUS_W(BUS_W), .VALID_CYC(VALID_CYC), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .az_n(az_n), .cap_valid(cap_valid),
   .oe_n(oe_n), .s1_o(s1_o), .s0_o(s0_o), .data_o(data_o)
);

// File: tb/res_byte_port_test.sv
module res_byte_port_test;
   localparam int CLK_P = 10;
   localparam int VALID = 20;
   localparam int CYC   = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        az_n = 1'b1, req_n = 1'b1, cap_valid = 1'b0, oe_n = 1'b0;
   logic [31:0] cap_time = '0, cap_integ = '0;
   logic        s1_o, s0_o, bus_oe_o;
   logic [7:0]  data_o;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   res_byte_port uut (
      .clk(clk), .rst_n(rst_n), .az_n(az_n), .req_n(req_n),
      .cap_valid(cap_valid), .cap_time(cap_time), .cap_integ(cap_integ),
      .oe_n(oe_n), .s1_o(s1_o), .s0_o(s0_o), .bus_oe_o(bus_oe_o), .data_o(data_o)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic pulse_cap(input logic [31:0] tw, input logic [31:0] iw);
      cap_time = tw; cap_integ = iw; cap_valid = 1'b1;
      @(negedge clk);
      cap_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(s1_o == 1'b0, "R1 s1 after reset", 32'(s1_o), 0);
      chk(s0_o == 1'b0, "R1 s0 after reset", 32'(s0_o), 0);
   endtask

   task automatic t_burst(input logic [31:0] tw, input logic [31:0] iw);
      logic [7:0] exp_b [8];
      int nrise = 0, hi_len = 0, last_rise = 0, last_hi = 0;
      bit prev_s0 = 0, ended = 0;
      logic [7:0] held = '0;
      for (int k = 0; k < 4; k++) begin
         exp_b[k]   = tw[31-8*k -: 8];
         exp_b[4+k] = iw[31-8*k -: 8];
      end
      req_n = 1'b0;
      repeat (6) @(negedge clk);
      chk(s1_o == 1'b0, "R2 no ack before capture", 32'(s1_o), 0);
      pulse_cap(tw, iw);
      chk(s1_o == 1'b1, "R2 ack after capture", 32'(s1_o), 1);
      for (int c = 1; c < 400 && !ended; c++) begin
         @(negedge clk);
         if (s0_o && !s1_o) chk(0, "R6 strobe outside busy", 0, 1);
         if (s0_o && !prev_s0) begin
            if (nrise < 8) chk(data_o == exp_b[nrise], "R3 byte value", 32'(data_o), 32'(exp_b[nrise]));
            if (nrise > 0) chk(c - last_rise == CYC, "R4 byte period", c - last_rise, CYC);
            nrise++; last_rise = c; hi_len = 0; held = data_o;
         end
         if (s0_o) begin
            hi_len++; last_hi = c;
            if (data_o != held) chk(0, "R5 data moved under strobe", 32'(data_o), 32'(held));
         end
         if (!s0_o && prev_s0) chk(hi_len == VALID, "R4 strobe width", hi_len, VALID);
         if (!s1_o) begin
            ended = 1;
            chk(c == last_hi + 1, "R6 s1 fall timing", c, last_hi + 1);
         end
         prev_s0 = s0_o;
      end
      chk(ended, "R6 s1 returned low", 32'(ended), 1);
      chk(nrise == 8, "R3 byte count", nrise, 8);
      req_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_oe();
      oe_n = 1'b1;
      @(negedge clk);
      chk(bus_oe_o == 1'b0, "R7 drive off", 32'(bus_oe_o), 0);
      chk(data_o == 8'h00, "R7 data zero when off", 32'(data_o), 0);
      oe_n = 1'b0;
      @(negedge clk);
      chk(bus_oe_o == 1'b1, "R7 drive on", 32'(bus_oe_o), 1);
   endtask

   task automatic t_idle_cap();
      bit bad = 0;
      pulse_cap(32'hDEAD_BEEF, 32'h1234_5678);
      repeat (10) begin @(negedge clk); if (s1_o) bad = 1; end
      chk(!bad, "R10 capture without request", 32'(bad), 0);
   endtask

   task automatic t_retrigger();
      bit bad = 0, ended = 0;
      req_n = 1'b0;
      repeat (6) @(negedge clk);
      pulse_cap(32'h0102_0304, 32'h0506_0708);
      repeat (100) @(negedge clk);
      req_n = 1'b1;
      repeat (5) @(negedge clk);
      req_n = 1'b0;
      for (int c = 0; c < 400 && !ended; c++) begin @(negedge clk); if (!s1_o) ended = 1; end
      chk(ended, "R9 first burst finished", 32'(ended), 1);
      repeat (6) @(negedge clk);
      pulse_cap(32'hAAAA_AAAA, 32'h5555_5555);
      repeat (10) begin @(negedge clk); if (s1_o) bad = 1; end
      chk(!bad, "R9 edge during busy ignored", 32'(bad), 0);
      pulse_cap(32'hAAAA_AAAA, 32'h5555_5555);
      repeat (10) begin @(negedge clk); if (s1_o) bad = 1; end
      chk(!bad, "R10 held-low request not re-armed", 32'(bad), 0);
      req_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_autozero();
      bit bad = 0;
      req_n = 1'b0;
      repeat (6) @(negedge clk);
      pulse_cap(32'hCAFE_F00D, 32'h0BAD_C0DE);
      repeat (70) @(negedge clk);
      az_n = 1'b0;
      repeat (5) @(negedge clk);
      repeat (10) begin @(negedge clk); if (!s1_o || s0_o) bad = 1; end
      chk(!bad, "R8 held no-data during autozero", 32'(bad), 0);
      req_n = 1'b1;
      az_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(s1_o == 1'b0, "R8 s1 released", 32'(s1_o), 0);
      bad = 0;
      pulse_cap(32'hCAFE_F00D, 32'h0BAD_C0DE);
      repeat (100) begin @(negedge clk); if (s1_o || s0_o) bad = 1; end
      chk(!bad, "R8 aborted transfer not resumed", 32'(bad), 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_burst(32'h1234_5678, 32'h9ABC_DEF0);
      t_burst(32'hFFFF_FFFF, 32'h0000_0001);
      t_oe();
      t_idle_cap();
      t_retrigger();
      t_autozero();
      t_burst(32'h8000_0000, 32'h0800_0000);
      finish_run();
   end
endmodule